// File: doc/BRIEF.md
# UART Register Bank with Interrupt Identification

This block is the processor-facing register file of a classic byte-wide serial port. A 32-bit bus reaches eight byte registers: control registers for interrupt enable, line format, modem outputs and a scratch byte, plus a 16-bit baud divisor. The line status, modem status and interrupt identification registers are read-only views built from flags supplied by the serial data path and the modem logic. The serial data path and modem logic themselves lie outside this block. The bank passes control values and transmit bytes to them and receives receive bytes and status events from them.

The bus is single-cycle. A read returns its data combinationally while the access is presented. A write, and any read side effect, takes hold at the next rising clock edge. The byte travels in one fixed lane of the data word. Setting the top bit of the line control register turns offsets 0 and 1 into the divisor halves. Reading the line status register clears its error flags, and reading the modem status register clears the whole register. A four-level priority encoder condenses the enabled sources into an identification code and drives a single interrupt line.

Top module: `uart_regbank`

## Requirements
- R1: After reset the interrupt enable, line control, modem control, scratch and divisor registers read 0, the identification register reads 0x01, `irq` is low, and line status reads 0x60 while `thr_empty` and `tsr_empty` are high.
- R2: A register byte is taken from and returned in bits 31:24 of the data word, and bits 23:0 of every read are zero.
- R3: While line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the high byte, and `divisor` shows {high, low}. Other offsets behave as usual. While bit 7 is clear, a write to offset 0 pulses `thr_wr` for one cycle, the cycle after the write, with the byte on `thr_data`, and offset 1 is the interrupt enable register.
- R4: Writes keep bits 3:0 of interrupt enable, bits 4:0 of modem control and all 8 bits of line control and scratch. Offsets 2, 5 and 6 are read-only.
- R5: `rx_push` loads `rx_byte` into the receive register and sets line status bit 0 (data ready). A read of offset 0 with bit 7 of line control clear returns that byte and clears bit 0. A push while bit 0 is already set sets bit 1 (overrun).
- R6: Pulses on `par_err`, `frm_err` and `brk_det` set line status bits 2, 3 and 4. Bits 5 and 6 mirror `thr_empty` and `tsr_empty`. A read of offset 5 returns the value and then clears bits 1 to 4 and leaves the other bits as they were.
- R7: Modem status bits 3:0 are sticky flags set by `msr_delta`, and bits 7:4 sample `msr_lines` at each clock edge. A read of offset 6 returns the value and then clears all 8 bits, so that a read in the next cycle returns 0.
- R8: The identification register (offset 2) reads 0x06 when enable bit 2 is set and a line status bit 1 to 4 is set. Otherwise it reads 0x04 when enable bit 0 is set and data ready is set. Otherwise it reads 0x02 when enable bit 1 is set and line status bit 5 is set. Otherwise it reads 0x00 when enable bit 3 is set and a modem status bit 3:0 is set. In every other case it reads 0x01.
- R9: `irq` is high exactly when bit 0 of the identification register is 0.
- R10: Offsets 8 and above read as zero and have no side effects. Writes to them change no register and cause no `thr_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Bus access this cycle |
| we | input | 1 | Access is a write |
| offset | input | 4 | Register offset |
| wdata | input | 32 | Write data, byte in bits 31:24 |
| rdata | output | 32 | Read data, byte in bits 31:24 |
| rx_push | input | 1 | Received byte available |
| rx_byte | input | 8 | Received byte |
| par_err | input | 1 | Parity error event |
| frm_err | input | 1 | Framing error event |
| brk_det | input | 1 | Break detected event |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shifter empty |
| msr_delta | input | 4 | Modem change event pulses |
| msr_lines | input | 4 | Modem input line levels |
| lcr_out | output | 8 | Line control value |
| mcr_out | output | 8 | Modem control value |
| divisor | output | 16 | Baud divisor |
| thr_wr | output | 1 | Transmit byte strobe |
| thr_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 32-bit word with the byte lane at bit 24, a 4-bit offset, and the combinational identification variant. The 4-bit offset makes offsets 8 to 15 reachable, so their low three bits alias real registers and a decode that ignores the upper offset bit would show up. With the combinational variant, a priority change appears in the same cycle as the state change behind it, so every level of the encoder can be stepped one at a time from the status inputs.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

   localparam int NUM_REGS = 8;
   localparam int OFS_BITS = 3;

   typedef enum logic [OFS_BITS-1:0] {
      OFS_DATA    = 3'd0,
      OFS_IEN     = 3'd1,
      OFS_IID     = 3'd2,
      OFS_LCTL    = 3'd3,
      OFS_MCTL    = 3'd4,
      OFS_LSTAT   = 3'd5,
      OFS_MSTAT   = 3'd6,
      OFS_SCRATCH = 3'd7
   } reg_ofs_e;

   // line status bit positions
   localparam int LS_DR   = 0;
   localparam int LS_OE   = 1;
   localparam int LS_PE   = 2;
   localparam int LS_FE   = 3;
   localparam int LS_BI   = 4;
   localparam int LS_THRE = 5;
   localparam int LS_TEMT = 6;

   // interrupt enable bit positions
   localparam int IEN_RXD   = 0;
   localparam int IEN_THRE  = 1;
   localparam int IEN_LINE  = 2;
   localparam int IEN_MODEM = 3;

   localparam int LCTL_ALIAS = 7;

   localparam logic [7:0] IID_NONE  = 8'h01;
   localparam logic [7:0] IID_LINE  = 8'h06;
   localparam logic [7:0] IID_RXD   = 8'h04;
   localparam logic [7:0] IID_THRE  = 8'h02;
   localparam logic [7:0] IID_MODEM = 8'h00;

   typedef struct packed {
      logic line;
      logic rxd;
      logic thre;
      logic modem;
   } irq_src_t;

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode import uart_rb_pkg::*; #(
   parameter int OFFSET_W = 4
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic                we,
   input  logic [OFFSET_W-1:0] offset,
   input  logic                alias_en,
   output logic                in_range,
   output logic [NUM_REGS-1:0] rd_hit,
   output logic [NUM_REGS-1:0] wr_hit,
   output logic                div_rd_lo,
   output logic                div_rd_hi,
   output logic                div_wr_lo,
   output logic                div_wr_hi
);

   generate
      if (OFFSET_W > OFS_BITS) begin : g_wide
         assign in_range = ~|offset[OFFSET_W-1:OFS_BITS];
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate

   logic rd_ok, wr_ok;
   assign rd_ok = sel & ~we & in_range;
   assign wr_ok = sel &  we & in_range;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      logic match, aliased;
      assign match   = (offset[OFS_BITS-1:0] == OFS_BITS'(i));
      assign aliased = alias_en && (i < 2);
      assign rd_hit[i] = rd_ok & match & ~aliased;
      assign wr_hit[i] = wr_ok & match & ~aliased;
   end

   assign div_rd_lo = rd_ok & alias_en & (offset[OFS_BITS-1:0] == OFS_DATA);
   assign div_rd_hi = rd_ok & alias_en & (offset[OFS_BITS-1:0] == OFS_IEN);
   assign div_wr_lo = wr_ok & alias_en & (offset[OFS_BITS-1:0] == OFS_DATA);
   assign div_wr_hi = wr_ok & alias_en & (offset[OFS_BITS-1:0] == OFS_IEN);

   // R3
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_hit, rd_hit, div_rd_lo, div_rd_hi, div_wr_lo, div_wr_hi}));

   // R10
   range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_range |-> (wr_hit == '0 && rd_hit == '0 && !div_wr_lo && !div_wr_hi));

endmodule

// File: rtl/uart_rb_status.sv
module uart_rb_status import uart_rb_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_push,
   input  logic [7:0] rx_byte,
   input  logic       par_err,
   input  logic       frm_err,
   input  logic       brk_det,
   input  logic       thr_empty,
   input  logic       tsr_empty,
   input  logic [3:0] msr_delta,
   input  logic [3:0] msr_lines,
   input  logic       rbr_rd,
   input  logic       lsr_rd,
   input  logic       msr_rd,
   output logic [7:0] rbr,
   output logic [7:0] lsr,
   output logic [7:0] msr
);

   logic [7:0] rbr_q;
   logic       ready_q;
   logic [3:0] err_q;      // {break, framing, parity, overrun}
   logic [3:0] delta_q;
   logic [3:0] lines_q;

   logic [3:0] err_set;
   assign err_set = {brk_det, frm_err, par_err, rx_push & ready_q & ~rbr_rd};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbr_q   <= '0;
         ready_q <= 1'b0;
         err_q   <= '0;
         delta_q <= '0;
         lines_q <= '0;
      end else begin
         if (rx_push) begin
            rbr_q   <= rx_byte;
            ready_q <= 1'b1;
         end else if (rbr_rd) begin
            ready_q <= 1'b0;
         end
         // new events win over a clear in the same cycle
         err_q   <= (lsr_rd ? 4'b0 : err_q) | err_set;
         delta_q <= (msr_rd ? 4'b0 : delta_q) | msr_delta;
         lines_q <= msr_rd ? 4'b0 : msr_lines;
      end
   end

   assign rbr = rbr_q;
   assign lsr = {1'b0, tsr_empty, thr_empty, err_q, ready_q};
   assign msr = {lines_q, delta_q};

   // R5
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && lsr[LS_DR] && !rbr_rd) |=> lsr[LS_OE]);

   // R5
   ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rbr_rd && !rx_push) |=> !lsr[LS_DR]);

   // R6
   lsr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !rx_push && !par_err && !frm_err && !brk_det) |=> (lsr[4:1] == 4'b0));

   // R7
   msr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd && msr_delta == 4'b0) |=> (msr == 8'h00));

endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq import uart_rb_pkg::*; #(
   parameter bit REG_IIR = 1'b0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] ien,
   input  logic       err_any,
   input  logic       data_ready,
   input  logic       thr_empty,
   input  logic       delta_any,
   output logic [7:0] iid,
   output logic       irq
);

   irq_src_t   src;
   logic [7:0] iid_next;
   logic       irq_next;

   assign src.line  = ien[IEN_LINE]  & err_any;
   assign src.rxd   = ien[IEN_RXD]   & data_ready;
   assign src.thre  = ien[IEN_THRE]  & thr_empty;
   assign src.modem = ien[IEN_MODEM] & delta_any;

   always_comb begin
      iid_next = IID_NONE;
      if (src.line)       iid_next = IID_LINE;
      else if (src.rxd)   iid_next = IID_RXD;
      else if (src.thre)  iid_next = IID_THRE;
      else if (src.modem) iid_next = IID_MODEM;
   end

   assign irq_next = |src;

   generate
      if (REG_IIR) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               iid <= IID_NONE;
               irq <= 1'b0;
            end else begin
               iid <= iid_next;
               irq <= irq_next;
            end
         end
      end else begin : g_comb
         assign iid = iid_next;
         assign irq = irq_next;

         // R8
         line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ien[IEN_LINE] && err_any) |-> (iid == IID_LINE));
      end
   endgenerate

   // R9
   irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !iid[0]);

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank import uart_rb_pkg::*; #(
   parameter int         DATA_W   = 32,
   parameter int         BYTE_LSB = 24,
   parameter int         OFFSET_W = 4,
   parameter logic [7:0] IER_MASK = 8'h0F,
   parameter logic [7:0] LCR_MASK = 8'hFF,
   parameter logic [7:0] MCR_MASK = 8'h1F,
   parameter bit         REG_IIR  = 1'b0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic                we,
   input  logic [OFFSET_W-1:0] offset,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic                rx_push,
   input  logic [7:0]          rx_byte,
   input  logic                par_err,
   input  logic                frm_err,
   input  logic                brk_det,
   input  logic                thr_empty,
   input  logic                tsr_empty,
   input  logic [3:0]          msr_delta,
   input  logic [3:0]          msr_lines,
   output logic [7:0]          lcr_out,
   output logic [7:0]          mcr_out,
   output logic [15:0]         divisor,
   output logic                thr_wr,
   output logic [7:0]          thr_data,
   output logic                irq
);

   localparam int BYTE_MSB = BYTE_LSB + 7;

   generate
      if (BYTE_MSB >= DATA_W) begin : g_bad_lane
         $error("byte lane does not fit in the data word");
      end
      if (OFFSET_W < OFS_BITS) begin : g_bad_offset
         $error("offset too narrow for eight registers");
      end
   endgenerate

   logic [7:0] wr_byte;
   logic       unused_lanes;
   assign wr_byte      = wdata[BYTE_MSB:BYTE_LSB];
   assign unused_lanes = ^wdata;

   logic [7:0] ier_q, lcr_q, mcr_q, scr_q, dll_q, dlh_q, thr_q;
   logic       thr_wr_q;

   logic                in_range;
   logic [NUM_REGS-1:0] rd_hit, wr_hit;
   logic                div_rd_lo, div_rd_hi, div_wr_lo, div_wr_hi;

   uart_rb_decode #(.OFFSET_W(OFFSET_W)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .we        (we),
      .offset    (offset),
      .alias_en  (lcr_q[LCTL_ALIAS]),
      .in_range  (in_range),
      .rd_hit    (rd_hit),
      .wr_hit    (wr_hit),
      .div_rd_lo (div_rd_lo),
      .div_rd_hi (div_rd_hi),
      .div_wr_lo (div_wr_lo),
      .div_wr_hi (div_wr_hi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q    <= '0;
         lcr_q    <= '0;
         mcr_q    <= '0;
         scr_q    <= '0;
         dll_q    <= '0;
         dlh_q    <= '0;
         thr_q    <= '0;
         thr_wr_q <= 1'b0;
      end else begin
         thr_wr_q <= wr_hit[OFS_DATA];
         if (wr_hit[OFS_DATA])    thr_q <= wr_byte;
         if (wr_hit[OFS_IEN])     ier_q <= wr_byte & IER_MASK;
         if (wr_hit[OFS_LCTL])    lcr_q <= wr_byte & LCR_MASK;
         if (wr_hit[OFS_MCTL])    mcr_q <= wr_byte & MCR_MASK;
         if (wr_hit[OFS_SCRATCH]) scr_q <= wr_byte;
         if (div_wr_lo)           dll_q <= wr_byte;
         if (div_wr_hi)           dlh_q <= wr_byte;
      end
   end

   logic [7:0] rbr, lsr, msr, iid;

   uart_rb_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_push   (rx_push),
      .rx_byte   (rx_byte),
      .par_err   (par_err),
      .frm_err   (frm_err),
      .brk_det   (brk_det),
      .thr_empty (thr_empty),
      .tsr_empty (tsr_empty),
      .msr_delta (msr_delta),
      .msr_lines (msr_lines),
      .rbr_rd    (rd_hit[OFS_DATA]),
      .lsr_rd    (rd_hit[OFS_LSTAT]),
      .msr_rd    (rd_hit[OFS_MSTAT]),
      .rbr       (rbr),
      .lsr       (lsr),
      .msr       (msr)
   );

   uart_rb_irq #(.REG_IIR(REG_IIR)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ien        (ier_q[3:0]),
      .err_any    (|lsr[LS_BI:LS_OE]),
      .data_ready (lsr[LS_DR]),
      .thr_empty  (lsr[LS_THRE]),
      .delta_any  (|msr[3:0]),
      .iid        (iid),
      .irq        (irq)
   );

   logic [7:0] rd_byte;
   always_comb begin
      rd_byte = ({8{rd_hit[OFS_DATA]}}    & rbr)
              | ({8{rd_hit[OFS_IEN]}}     & ier_q)
              | ({8{rd_hit[OFS_IID]}}     & iid)
              | ({8{rd_hit[OFS_LCTL]}}    & lcr_q)
              | ({8{rd_hit[OFS_MCTL]}}    & mcr_q)
              | ({8{rd_hit[OFS_LSTAT]}}   & lsr)
              | ({8{rd_hit[OFS_MSTAT]}}   & msr)
              | ({8{rd_hit[OFS_SCRATCH]}} & scr_q)
              | ({8{div_rd_lo}}           & dll_q)
              | ({8{div_rd_hi}}           & dlh_q);
   end

   assign rdata    = {{(DATA_W-8){1'b0}}, rd_byte} << BYTE_LSB;
   assign lcr_out  = lcr_q;
   assign mcr_out  = mcr_q;
   assign divisor  = {dlh_q, dll_q};
   assign thr_wr   = thr_wr_q;
   assign thr_data = thr_q;

   // R4
   ien_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q & ~IER_MASK) == 8'h00);

   // R10
   range_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !we && !in_range) |-> (rdata == '0));

   // R3
   alias_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && we && lcr_q[LCTL_ALIAS]) |=> !thr_wr);

endmodule

// File: tb/uart_regbank_test.sv
module uart_regbank_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, we = 1'b0;
   logic [3:0]  offset = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rx_push = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        par_err = 1'b0, frm_err = 1'b0, brk_det = 1'b0;
   logic        thr_empty = 1'b1, tsr_empty = 1'b1;
   logic [3:0]  msr_delta = '0, msr_lines = '0;
   logic [7:0]  lcr_out, mcr_out, thr_data;
   logic [15:0] divisor;
   logic        thr_wr, irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_regbank uut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .offset(offset),
      .wdata(wdata), .rdata(rdata), .rx_push(rx_push), .rx_byte(rx_byte),
      .par_err(par_err), .frm_err(frm_err), .brk_det(brk_det),
      .thr_empty(thr_empty), .tsr_empty(tsr_empty), .msr_delta(msr_delta),
      .msr_lines(msr_lines), .lcr_out(lcr_out), .mcr_out(mcr_out),
      .divisor(divisor), .thr_wr(thr_wr), .thr_data(thr_data), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks enter and leave just after a falling edge
   task automatic bus_write(input logic [3:0] ofs, input logic [7:0] val);
      sel = 1'b1; we = 1'b1; offset = ofs; wdata = {val, 24'h5A_C3_96};
      @(negedge clk);
      sel = 1'b0; we = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [3:0] ofs, output logic [31:0] val);
      sel = 1'b1; we = 1'b0; offset = ofs;
      #1 val = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic read_chk(input string req, input logic [3:0] ofs, input logic [7:0] exp);
      logic [31:0] v;
      bus_read(ofs, v);
      check(req, v, {exp, 24'h0});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      rx_push = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 irq", {31'b0, irq}, 0);
      check("R1 divisor", {16'b0, divisor}, 0);
      read_chk("R1 ier", 4'd1, 8'h00);
      read_chk("R1 lcr", 4'd3, 8'h00);
      read_chk("R1 mcr", 4'd4, 8'h00);
      read_chk("R1 scr", 4'd7, 8'h00);
      read_chk("R1 iid", 4'd2, 8'h01);
      read_chk("R1 lsr", 4'd5, 8'h60);
   endtask

   task automatic t_lanes_masks;
      bus_write(4'd7, 8'hA5);
      read_chk("R2 scr lane", 4'd7, 8'hA5);
      bus_write(4'd1, 8'hFF);
      read_chk("R4 ier mask", 4'd1, 8'h0F);
      bus_write(4'd4, 8'hFF);
      read_chk("R4 mcr mask", 4'd4, 8'h1F);
      check("R4 mcr_out", {24'b0, mcr_out}, 32'h1F);
      bus_write(4'd3, 8'h7F);
      read_chk("R4 lcr full", 4'd3, 8'h7F);
      bus_write(4'd5, 8'h00);
      bus_write(4'd2, 8'hFF);
      read_chk("R4 lsr read-only", 4'd5, 8'h60);
      bus_write(4'd1, 8'h00);
      bus_write(4'd4, 8'h00);
   endtask

   task automatic t_alias;
      bus_write(4'd3, 8'h83);
      bus_write(4'd0, 8'h34);
      check("R3 no thr strobe", {31'b0, thr_wr}, 0);
      bus_write(4'd1, 8'h12);
      check("R3 divisor", {16'b0, divisor}, 32'h1234);
      read_chk("R3 div lo", 4'd0, 8'h34);
      read_chk("R3 div hi", 4'd1, 8'h12);
      read_chk("R3 scr normal", 4'd7, 8'hA5);
      bus_write(4'd3, 8'h03);
      read_chk("R3 ier untouched", 4'd1, 8'h00);
      check("R3 divisor kept", {16'b0, divisor}, 32'h1234);
      bus_write(4'd0, 8'h5A);
      check("R3 thr strobe", {31'b0, thr_wr}, 1);
      check("R3 thr data", {24'b0, thr_data}, 32'h5A);
      idle(1);
      check("R3 thr one cycle", {31'b0, thr_wr}, 0);
   endtask

   task automatic t_rx;
      push(8'h3C);
      read_chk("R5 ready", 4'd5, 8'h61);
      read_chk("R5 rbr", 4'd0, 8'h3C);
      read_chk("R5 ready clr", 4'd5, 8'h60);
      push(8'h11);
      push(8'h22);
      read_chk("R5 overrun", 4'd5, 8'h63);
      read_chk("R6 oe cleared dr kept", 4'd5, 8'h61);
      read_chk("R5 latest byte", 4'd0, 8'h22);
      par_err = 1'b1; frm_err = 1'b1; brk_det = 1'b1;
      idle(1);
      par_err = 1'b0; frm_err = 1'b0; brk_det = 1'b0;
      read_chk("R6 errors", 4'd5, 8'h7C);
      read_chk("R6 errors cleared", 4'd5, 8'h60);
      tsr_empty = 1'b0;
      read_chk("R6 temt mirror", 4'd5, 8'h20);
      tsr_empty = 1'b1;
   endtask

   task automatic t_msr;
      msr_lines = 4'b1010; msr_delta = 4'b0101;
      idle(1);
      msr_delta = 4'b0000;
      read_chk("R7 value", 4'd6, 8'hA5);
      read_chk("R7 cleared", 4'd6, 8'h00);
      idle(1);
      read_chk("R7 lines resampled", 4'd6, 8'hA0);
      idle(1);
   endtask

   task automatic t_irq;
      bus_write(4'd1, 8'h0F);
      read_chk("R8 thre", 4'd2, 8'h02);
      check("R9 irq thre", {31'b0, irq}, 1);
      thr_empty = 1'b0; tsr_empty = 1'b0;
      #1 check("R9 irq none", {31'b0, irq}, 0);
      read_chk("R8 none", 4'd2, 8'h01);
      msr_delta = 4'b0001;
      idle(1);
      msr_delta = 4'b0000;
      check("R9 irq modem", {31'b0, irq}, 1);
      read_chk("R8 modem", 4'd2, 8'h00);
      thr_empty = 1'b1;
      read_chk("R8 thre over modem", 4'd2, 8'h02);
      push(8'h77);
      read_chk("R8 rxd over thre", 4'd2, 8'h04);
      brk_det = 1'b1;
      idle(1);
      brk_det = 1'b0;
      read_chk("R8 line first", 4'd2, 8'h06);
      read_chk("R6 lsr with break", 4'd5, 8'h31);
      read_chk("R8 back to rxd", 4'd2, 8'h04);
      read_chk("R5 rbr irq", 4'd0, 8'h77);
      read_chk("R8 back to thre", 4'd2, 8'h02);
      bus_write(4'd1, 8'h08);
      read_chk("R8 modem only", 4'd2, 8'h00);
      bus_write(4'd1, 8'h00);
      check("R9 irq disabled", {31'b0, irq}, 0);
      read_chk("R8 disabled", 4'd2, 8'h01);
      tsr_empty = 1'b1;
   endtask

   task automatic t_range;
      logic [31:0] v;
      bus_write(4'd9, 8'hFF);
      read_chk("R10 ier alias", 4'd1, 8'h00);
      bus_write(4'd15, 8'hEE);
      read_chk("R10 scr alias", 4'd7, 8'hA5);
      bus_write(4'd8, 8'h99);
      check("R10 no thr strobe", {31'b0, thr_wr}, 0);
      push(8'h44);
      bus_read(4'd8, v);
      check("R10 read zero", v, 0);
      read_chk("R10 ready kept", 4'd5, 8'h61);
      bus_read(4'd14, v);
      check("R10 msr alias zero", v, 0);
      read_chk("R10 rbr", 4'd0, 8'h44);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lanes_masks();
      t_alias();
      t_rx();
      t_msr();
      t_irq();
      t_range();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule